// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block is the data-register side of a boundary-scan path for the pins of a programmable-logic device. An external TAP controller supplies the capture, shift and update strobes and the test clock. Every bidirectional pin contributes two cells to the serial chain. One cell holds the value driven onto the pin and the other holds its output enable. Every input-only pin contributes one reduced cell that can only capture and shift. The number of pins of each kind and whether the input-only cells sit at the serial-in end or the serial-out end are parameters. The cell order is fixed at elaboration.

In normal operation the core's data and enable reach the pads untouched. With the external-test mode selected, the pads are driven from the update stages instead. Three controls can pull every output enable low whatever the mode: a high-impedance request, a configuration-mode flag and an active-low test enable. Serial data enters at `tdi`. It leaves at `tdo`, which is retimed on the falling test-clock edge.

Top module: `bsc_chain`

## Requirements
- R1: The chain holds 2*N_IO + N_IN cells, counted from `tdi` (position 0) to `tdo`. With IN_FIRST=0, I/O pin i has its enable cell at position 2i and its data cell at 2i+1, and input-only pin j sits at 2*N_IO+j. With IN_FIRST=1 the input-only cells take positions 0..N_IN-1 and the I/O cells follow in the same pairwise order.
- R2: On each rising `tck` edge with `shift_dr` high, every cell takes the value of its tdi-side neighbour and position 0 takes `tdi`. Shift has priority over `capture_dr` in the same cycle.
- R3: On a rising edge with `capture_dr` high and `shift_dr` low, each data cell loads `pad_in[i]`, each enable cell loads `core_oe[i]` and each input-only cell loads `in_pin[j]`. With neither strobe high, the shift stages hold.
- R4: The update stages of the I/O cells load their shift stages on a falling `tck` edge with `update_dr` high. Otherwise they hold, so shifting alone never disturbs the pads.
- R5: With `extest` low, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`, unless the outputs are forced off (R7).
- R6: With `extest` high, `pad_out[i]` and `pad_oe[i]` come from the data and enable update stages of pin i, and the core values have no effect.
- R7: While `force_hiz` is high, `cfg_mode` is high or `test_oe_n` is low, every bit of `pad_oe` is 0 in either mode.
- R8: `tdo` changes only on falling `tck` edges. After each falling edge it shows the cell at the last chain position.
- R9: `rst_n` low at a clock edge clears all shift stages (rising edge), all update stages (falling edge, so enables are off and data is 0) and `tdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_dr | input | 1 | Load pin and core values into the shift stages |
| shift_dr | input | 1 | Move the chain one position toward `tdo` |
| update_dr | input | 1 | Copy shift stages into update stages (falling edge) |
| extest | input | 1 | Drive pads from update stages |
| force_hiz | input | 1 | Force all output enables off |
| cfg_mode | input | 1 | Configuration in progress; forces enables off |
| test_oe_n | input | 1 | Active-low test enable; low forces enables off |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge retimed |
| core_out | input | N_IO | Core data for each I/O pin |
| core_oe | input | N_IO | Core output enable for each I/O pin |
| pad_in | input | N_IO | Value seen at each I/O pad |
| pad_out | output | N_IO | Data driven to each I/O pad |
| pad_oe | output | N_IO | Output enable of each I/O pad |
| in_pin | input | N_IN | Input-only pin values |

## Verification
The strobes that collide are shift and capture. The bench first loads a known pattern and then holds both `shift_dr` and `capture_dr` high for one rising edge. The capture sources are set to values that differ from what a shift would produce. The chain is then shifted out, and the result is judged against the pattern moved by one place with the new `tdi` bit at position 0, never against the captured values. The same is done for the force-off controls against the external-test mode: forcing must win with pattern enables of all ones loaded into the update stages.

// File: rtl/bsc_pkg.sv
// Shared helpers for the boundary-scan chain: cell positions counted from tdi.
// Assumes at least one I/O pin and one input-only pin.
package bsc_pkg;

    // Position of the enable cell of I/O pin 'pin'; its data cell follows it.
    function automatic int unsigned io_slot(int unsigned pin, int unsigned n_io,
                                            int unsigned n_in, bit in_first);
        return in_first ? (n_in + 2 * pin) : (2 * pin);
    endfunction

    // Position of input-only cell 'pin'.
    function automatic int unsigned in_slot(int unsigned pin, int unsigned n_io,
                                            int unsigned n_in, bit in_first);
        return in_first ? pin : (2 * n_io + pin);
    endfunction

endpackage

// File: rtl/bsc_io_pair.sv
// Two scan cells for one bidirectional pin: enable cell (tdi side) then data cell.
// Shift stages run on the rising test-clock edge; the update stages are loaded
// during the low phase of tck (falling edge), as a transparent-low latch would be.
// Assumes strobes are stable around both edges and reset is synchronous.
module bsc_io_pair (
    input  logic tck,
    input  logic rst_n,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    input  logic si,
    input  logic cap_oe,
    input  logic cap_d,
    output logic so_oe,
    output logic so_d,
    output logic upd_oe,
    output logic upd_d
);

    // Shift/capture stages: shift wins over capture.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            so_oe <= 1'b0;
            so_d  <= 1'b0;
        end else if (shift_dr) begin
            so_oe <= si;
            so_d  <= so_oe;
        end else if (capture_dr) begin
            so_oe <= cap_oe;
            so_d  <= cap_d;
        end
    end

    // Update stages: reset to the non-driving state, load on update.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            upd_oe <= 1'b0;
            upd_d  <= 1'b0;
        end else if (update_dr) begin
            upd_oe <= so_oe;
            upd_d  <= so_d;
        end
    end

endmodule

// File: rtl/bsc_in_cell.sv
// Reduced scan cell for an input-only pin: capture and shift, no update stage.
// Assumes synchronous reset sampled on the rising test-clock edge.
module bsc_in_cell (
    input  logic tck,
    input  logic rst_n,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic si,
    input  logic cap,
    output logic so
);

    // Single shift/capture stage, shift has priority.
    always_ff @(posedge tck) begin
        if (!rst_n)          so <= 1'b0;
        else if (shift_dr)   so <= si;
        else if (capture_dr) so <= cap;
    end

endmodule

// File: rtl/bsc_chain.sv
// Boundary-scan data chain for N_IO bidirectional and N_IN input-only pins.
// Cell order from tdi to tdo is set by IN_FIRST at elaboration. Pads take core
// values in normal mode and update-stage values under extest; three controls
// force every output enable off. tdo is retimed on the falling tck edge.
// Assumes an external TAP controller produces mutually timed strobes on tck.
module bsc_chain #(
    parameter int unsigned N_IO     = 4,
    parameter int unsigned N_IN     = 3,
    parameter bit          IN_FIRST = 1'b0
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            extest,
    input  logic            force_hiz,
    input  logic            cfg_mode,
    input  logic            test_oe_n,
    input  logic            tdi,
    output logic            tdo,
    input  logic [N_IO-1:0] core_out,
    input  logic [N_IO-1:0] core_oe,
    input  logic [N_IO-1:0] pad_in,
    output logic [N_IO-1:0] pad_out,
    output logic [N_IO-1:0] pad_oe,
    input  logic [N_IN-1:0] in_pin
);

    localparam int unsigned LEN = 2 * N_IO + N_IN;

    logic [LEN:0]    link;      // link[p] feeds cell p; link[p+1] is its output
    logic [LEN-1:0]  chain_q;   // shift stages in chain order
    logic [N_IO-1:0] upd_oe_q;
    logic [N_IO-1:0] upd_d_q;
    logic            force_off;

    assign link[0]   = tdi;
    assign chain_q   = link[LEN:1];
    assign force_off = force_hiz | cfg_mode | ~test_oe_n;

    // One cell pair and one pad mux per bidirectional pin.
    for (genvar i = 0; i < N_IO; i++) begin : g_io
        localparam int unsigned P = bsc_pkg::io_slot(i, N_IO, N_IN, IN_FIRST);
        logic so_oe_w, so_d_w;

        bsc_io_pair u_pair (
            .tck        (tck),
            .rst_n      (rst_n),
            .capture_dr (capture_dr),
            .shift_dr   (shift_dr),
            .update_dr  (update_dr),
            .si         (link[P]),
            .cap_oe     (core_oe[i]),
            .cap_d      (pad_in[i]),
            .so_oe      (so_oe_w),
            .so_d       (so_d_w),
            .upd_oe     (upd_oe_q[i]),
            .upd_d      (upd_d_q[i])
        );

        assign link[P+1] = so_oe_w;
        assign link[P+2] = so_d_w;

        // Pad selection: core or update stage, enable gated by force-off.
        always_comb begin
            pad_out[i] = extest ? upd_d_q[i] : core_out[i];
            pad_oe[i]  = force_off ? 1'b0 : (extest ? upd_oe_q[i] : core_oe[i]);
        end
    end

    // One reduced cell per input-only pin.
    for (genvar j = 0; j < N_IN; j++) begin : g_in
        localparam int unsigned P = bsc_pkg::in_slot(j, N_IO, N_IN, IN_FIRST);

        bsc_in_cell u_cell (
            .tck        (tck),
            .rst_n      (rst_n),
            .capture_dr (capture_dr),
            .shift_dr   (shift_dr),
            .si         (link[P]),
            .cap        (in_pin[j]),
            .so         (link[P+1])
        );
    end

    // Serial output retimed on the falling edge of tck.
    always_ff @(negedge tck) begin
        if (!rst_n) tdo <= 1'b0;
        else        tdo <= link[LEN];
    end

endmodule

// File: rtl/bsc_chain_chk.sv
// Property checker for bsc_chain, attached by bind. Observes ports plus the
// shift and update stages brought out of the top module.
module bsc_chain_chk #(
    parameter int unsigned N_IO = 4,
    parameter int unsigned N_IN = 3
) (
    input logic                     tck,
    input logic                     rst_n,
    input logic                     capture_dr,
    input logic                     shift_dr,
    input logic                     update_dr,
    input logic                     extest,
    input logic                     force_hiz,
    input logic                     cfg_mode,
    input logic                     test_oe_n,
    input logic                     tdi,
    input logic                     tdo,
    input logic [N_IO-1:0]          core_out,
    input logic [N_IO-1:0]          pad_out,
    input logic [N_IO-1:0]          pad_oe,
    input logic [N_IO-1:0]          upd_d_q,
    input logic [N_IO-1:0]          upd_oe_q,
    input logic [2*N_IO+N_IN-1:0]   chain_q
);

    localparam int unsigned LEN = 2 * N_IO + N_IN;

    AST_FORCE_OFF: assert property (@(posedge tck) disable iff (!rst_n)
        (force_hiz || cfg_mode || !test_oe_n) |-> (pad_oe == '0)); // R7

    AST_CORE_PASS: assert property (@(posedge tck) disable iff (!rst_n)
        !extest |-> (pad_out == core_out)); // R5

    AST_EXT_DATA: assert property (@(posedge tck) disable iff (!rst_n)
        extest |-> (pad_out == upd_d_q)); // R6

    AST_SHIFT_HEAD: assert property (@(posedge tck) disable iff (!rst_n)
        shift_dr |=> (chain_q[0] == $past(tdi))); // R2

    AST_SHIFT_MOVE: assert property (@(posedge tck) disable iff (!rst_n)
        shift_dr |=> (chain_q[LEN-1:1] == $past(chain_q[LEN-2:0]))); // R2

    AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
        (!shift_dr && !capture_dr) |=> $stable(chain_q)); // R3

    AST_UPD_HOLD: assert property (@(negedge tck) disable iff (!rst_n)
        !update_dr |=> ($stable(upd_d_q) && $stable(upd_oe_q))); // R4

    AST_TDO_RETIME: assert property (@(negedge tck) disable iff (!rst_n)
        rst_n |=> (tdo == $past(chain_q[LEN-1]))); // R8

    AST_RESET_CLEAR: assert property (@(posedge tck)
        !rst_n |=> (chain_q == '0)); // R9

endmodule

bind bsc_chain bsc_chain_chk #(.N_IO(N_IO), .N_IN(N_IN)) u_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .extest     (extest),
    .force_hiz  (force_hiz),
    .cfg_mode   (cfg_mode),
    .test_oe_n  (test_oe_n),
    .tdi        (tdi),
    .tdo        (tdo),
    .core_out   (core_out),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .upd_d_q    (upd_d_q),
    .upd_oe_q   (upd_oe_q),
    .chain_q    (chain_q)
);

// File: tb/tb_bsc_chain.sv
// Self-checking bench: sweeps core and force inputs, shifts patterns through the
// chain and predicts every cell position arithmetically from the requirements.
module tb_bsc_chain;

    localparam int unsigned N_IO = 4;
    localparam int unsigned N_IN = 3;
    localparam int unsigned LEN  = 2 * N_IO + N_IN;

    logic tck = 1'b0;
    logic rst_n, capture_dr, shift_dr, update_dr, extest;
    logic force_hiz, cfg_mode, test_oe_n, tdi, tdo;
    logic [N_IO-1:0] core_out, core_oe, pad_in, pad_out, pad_oe;
    logic [N_IN-1:0] in_pin;

    int checks = 0;
    int errors = 0;
    logic [LEN-1:0] seen, pat_a, pat_b, pat_c, exp_v;
    logic [N_IO-1:0] exp_d, exp_oe;
    logic old_last;

    always #10 tck = ~tck;   // 50 MHz

    bsc_chain #(.N_IO(N_IO), .N_IN(N_IN), .IN_FIRST(1'b0)) dut (
        .tck(tck), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .extest(extest), .force_hiz(force_hiz),
        .cfg_mode(cfg_mode), .test_oe_n(test_oe_n), .tdi(tdi), .tdo(tdo),
        .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .in_pin(in_pin)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Advance to 15 ns after the next rising edge (past the falling edge).
    task automatic tick();
        @(posedge tck);
        #15;
    endtask

    // Shift 'load' in (position LEN-1 first) while recording what leaves tdo.
    task automatic shift_vec(input logic [LEN-1:0] load, output logic [LEN-1:0] got);
        for (int i = 0; i < LEN; i++) begin
            got[LEN-1-i] = tdo;
            tdi      = load[LEN-1-i];
            shift_dr = 1'b1;
            tick();
        end
        shift_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        tick();
        update_dr = 1'b0;
    endtask

    task automatic do_capture();
        capture_dr = 1'b1;
        tick();
        capture_dr = 1'b0;
    endtask

    // Expected capture image from the R1 positions and R3 sources.
    function automatic logic [LEN-1:0] cap_image(input logic [N_IO-1:0] oe,
                                                 input logic [N_IO-1:0] pin,
                                                 input logic [N_IN-1:0] inp);
        logic [LEN-1:0] v;
        for (int i = 0; i < N_IO; i++) begin
            v[2*i]   = oe[i];
            v[2*i+1] = pin[i];
        end
        for (int j = 0; j < N_IN; j++) v[2*N_IO+j] = inp[j];
        return v;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
        extest = 1'b1; force_hiz = 1'b0; cfg_mode = 1'b0; test_oe_n = 1'b1;
        tdi = 1'b1; core_out = '1; core_oe = '1; pad_in = '0; in_pin = '0;
        repeat (3) tick();

        // R9: reset leaves update stages non-driving and tdo low.
        check("R9 pad_oe", pad_oe, 0);
        check("R9 pad_out", pad_out, 0);
        check("R9 tdo", tdo, 0);
        rst_n  = 1'b1;
        extest = 1'b0;
        tick();

        // R5: normal mode sweep over every core data/enable combination.
        for (int d = 0; d < (1 << N_IO); d++) begin
            for (int e = 0; e < (1 << N_IO); e++) begin
                core_out = d[N_IO-1:0];
                core_oe  = e[N_IO-1:0];
                #1;
                check("R5 pad_out", pad_out, d[N_IO-1:0]);
                check("R5 pad_oe", pad_oe, e[N_IO-1:0]);
            end
        end
        tick();

        // R7: force-off sweep in normal mode with all core enables on.
        core_oe = '1;
        for (int f = 0; f < 8; f++) begin
            force_hiz = f[0];
            cfg_mode  = f[1];
            test_oe_n = ~f[2];
            #1;
            check("R7 normal", pad_oe, (f != 0) ? 0 : {N_IO{1'b1}});
        end
        force_hiz = 1'b0; cfg_mode = 1'b0; test_oe_n = 1'b1;
        tick();

        // R1/R9: first shift returns the reset image, second returns pattern A.
        pat_a = 11'h5A3;
        pat_b = 11'h2CE;
        shift_vec(pat_a, seen);
        check("R9 reset chain", seen, 0);
        shift_vec(pat_b, seen);
        check("R1 length", seen, pat_a);

        // R4/R6: update then extest drives pads from pattern B.
        do_update();
        extest = 1'b1;
        for (int i = 0; i < N_IO; i++) begin
            exp_oe[i] = pat_b[2*i];
            exp_d[i]  = pat_b[2*i+1];
        end
        core_out = ~exp_d; core_oe = ~exp_oe;
        #1;
        check("R6 pad_out", pad_out, exp_d);
        check("R6 pad_oe", pad_oe, exp_oe);
        core_out = exp_d; core_oe = exp_oe;
        #1;
        check("R6 core ignored", pad_out, exp_d);
        tick();

        // R4: shifting without update leaves the pads alone.
        pat_c = 11'h7FF;
        shift_vec(pat_c, seen);
        check("R1 readback B", seen, pat_b);
        repeat (2) tick();
        check("R4 hold out", pad_out, exp_d);
        check("R4 hold oe", pad_oe, exp_oe);
        do_update();
        check("R4 update out", pad_out, {N_IO{1'b1}});
        check("R4 update oe", pad_oe, {N_IO{1'b1}});

        // R7: each force control beats extest with all enables loaded.
        force_hiz = 1'b1; #1; check("R7 hiz extest", pad_oe, 0);
        force_hiz = 1'b0; cfg_mode = 1'b1; #1; check("R7 cfg extest", pad_oe, 0);
        cfg_mode = 1'b0; test_oe_n = 1'b0; #1; check("R7 toe extest", pad_oe, 0);
        test_oe_n = 1'b1; #1; check("R7 release", pad_oe, {N_IO{1'b1}});
        extest = 1'b0;
        tick();

        // R3: capture two distinct pin/core images and shift them out.
        for (int k = 0; k < 2; k++) begin
            pad_in  = k ? 4'b0101 : 4'b1010;
            core_oe = k ? 4'b1001 : 4'b0110;
            in_pin  = k ? 3'b010 : 3'b101;
            do_capture();
            shift_vec('0, seen);
            check("R3 capture", seen, cap_image(core_oe, pad_in, in_pin));
        end

        // R2: shift and capture together; shift must win.
        shift_vec(pat_a, seen);
        pad_in = '1; core_oe = '1; in_pin = '1;
        tdi = 1'b0; shift_dr = 1'b1; capture_dr = 1'b1;
        tick();
        shift_dr = 1'b0; capture_dr = 1'b0;
        exp_v = {pat_a[LEN-2:0], 1'b0};
        shift_vec('0, seen);
        check("R2 shift over capture", seen, exp_v);

        // R8: tdo keeps its value past the rising edge, changes after the falling one.
        shift_vec(11'h400, seen);          // last position holds 1, others 0
        old_last = tdo;
        check("R8 preload", old_last, 1);
        tdi = 1'b0; shift_dr = 1'b1;
        @(posedge tck);
        #3;
        check("R8 before fall", tdo, old_last);
        #9;
        check("R8 after fall", tdo, 0);
        #3;
        shift_dr = 1'b0;

        // R9: mid-run reset clears update stages, returns pads to non-driving.
        extest = 1'b1;
        rst_n = 1'b0;
        tick();
        check("R9 mid reset oe", pad_oe, 0);
        check("R9 mid reset tdo", tdo, 0);
        rst_n = 1'b1;
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule